// File: doc/BRIEF.md
# PCIe Configuration Access Router

This block sits between a host-side request port and two configuration targets of a PCIe root port. Each request names a bus number, a device (slot) number, a function number and a 12-bit register offset, plus write data and byte enables. The block screens the request against the bus topology: only one device can sit below the root port, and only one slot exists on the bus directly below it. An allowed request then goes either to the root port's own control/status space or, for any other bus, through a remote configuration window.

A remote access takes two steps. The block first writes a window word that carries the bus, slot and function in its upper sixteen bits. It then issues the access into the window region. Because that one window word is shared, the block takes a single request at a time and raises `req_ready` again only after the response. A rejected request never reaches a target. A rejected read completes with all ones and a rejected write completes with nothing written.

The root bus number and the secondary bus number are held in two small registers that software loads through a dedicated strobe.

Top module: `cfg_access_router`

## Requirements
- R1: A request whose bus equals the root bus number and whose combined device/function field is non-zero is rejected.
- R2: A request whose bus equals the secondary bus number (and not the root bus number) is rejected when its device number is non-zero, whatever the function; device 0 with any function is forwarded remotely.
- R3: An allowed request to the root bus raises `loc_valid` with `loc_addr` = LOC_BASE + offset (offset bits 1:0 forced to zero), passes write data, byte enables and direction unchanged, and holds them until `loc_ack`.
- R4: A request to any bus other than the root bus that passes the filter pulses `win_we` for one cycle with `win_data` = bus in bits 31..24, device in 23..19, function in 18..16 and zeros in 15..0, and `rem_valid` rises in the very next cycle.
- R5: The remote access drives `rem_addr` = REM_BASE + offset (bits 1:0 zero), passes write data, byte enables and direction unchanged, and holds them until `rem_ack`.
- R6: A rejected request touches no target strobe and raises `rsp_valid` in the cycle right after acceptance, with `rsp_rdata` = 0xFFFFFFFF for a read and 0 for a write.
- R7: `req_ready` is low from the cycle after acceptance until the response cycle has ended, so at most one request is in flight.
- R8: Exactly one cycle of `rsp_valid` completes each request. For a forwarded read it carries the target's read data, captured on the acknowledge edge. For any write it carries 0.
- R9: The root and secondary bus numbers reset to 0 and 1. A `busnum_we` strobe loads both. A request accepted on the same edge as the load is filtered and routed with the old values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busnum_we | input | 1 | Load strobe for the bus-number registers |
| busnum_root_in | input | 8 | New root bus number |
| busnum_sec_in | input | 8 | New secondary bus number |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bus | input | 8 | Target bus number |
| req_dev | input | 5 | Target device (slot) number |
| req_fn | input | 3 | Target function number |
| req_off | input | 12 | Register byte offset (dword aligned) |
| req_wdata | input | DATA_W | Write data |
| req_be | input | DATA_W/8 | Byte enables |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_rdata | output | DATA_W | Read data or all ones / zero |
| loc_valid | output | 1 | Local space access strobe |
| loc_write | output | 1 | Local access direction |
| loc_addr | output | ADDR_W | Local access address |
| loc_wdata | output | DATA_W | Local write data |
| loc_be | output | DATA_W/8 | Local byte enables |
| loc_ack | input | 1 | Local access complete |
| loc_rdata | input | DATA_W | Local read data |
| win_we | output | 1 | Window word write strobe |
| win_data | output | 32 | Window word with bus/device/function |
| rem_valid | output | 1 | Remote window access strobe |
| rem_write | output | 1 | Remote access direction |
| rem_addr | output | ADDR_W | Remote access address |
| rem_wdata | output | DATA_W | Remote write data |
| rem_be | output | DATA_W/8 | Remote byte enables |
| rem_ack | input | 1 | Remote access complete |
| rem_rdata | input | DATA_W | Remote read data |

## Verification
A load of the bus-number registers and the acceptance of a request can fall on the same clock edge. In that case the request must be judged with the old numbers. The bench provokes this by driving `busnum_we` with new numbers in the same cycle as a request whose verdict differs between the old and new settings. It then checks the routing and the response against a model that applies the load only after that request. A follow-up request confirms that the new numbers are in force from the next acceptance on.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;
   localparam int BUS_W = 8;
   localparam int DEV_W = 5;
   localparam int FN_W  = 3;
   localparam int OFF_W = 12;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_LOCAL,
      ST_WINDOW,
      ST_REMOTE,
      ST_RESP
   } rtr_state_t;

   typedef enum logic [1:0] {
      TGT_REJECT,
      TGT_LOCAL,
      TGT_REMOTE
   } rtr_target_t;

   typedef struct packed {
      logic [BUS_W-1:0] bus;
      logic [DEV_W-1:0] dev;
      logic [FN_W-1:0]  fn;
   } bdf_t;
endpackage

// File: rtl/cfg_bus_regs.sv
module cfg_bus_regs
   import cfg_router_pkg::*;
#(
   parameter logic [BUS_W-1:0] ROOT_RST = 8'd0,
   parameter logic [BUS_W-1:0] SEC_RST  = 8'd1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [BUS_W-1:0] root_in,
   input  logic [BUS_W-1:0] sec_in,
   output logic [BUS_W-1:0] root_q,
   output logic [BUS_W-1:0] sec_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         root_q <= ROOT_RST;
         sec_q  <= SEC_RST;
      end else if (we) begin
         root_q <= root_in;
         sec_q  <= sec_in;
      end
   end

   // R9
   busnum_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> ($stable(root_q) && $stable(sec_q)));
endmodule

// File: rtl/cfg_filter.sv
module cfg_filter
   import cfg_router_pkg::*;
(
   input  bdf_t             bdf,
   input  logic [BUS_W-1:0] root_bus,
   input  logic [BUS_W-1:0] sec_bus,
   output rtr_target_t      target
);
   always_comb begin
      if (bdf.bus == root_bus)
         target = ({bdf.dev, bdf.fn} == '0) ? TGT_LOCAL : TGT_REJECT;
      else if (bdf.bus == sec_bus)
         target = (bdf.dev == '0) ? TGT_REMOTE : TGT_REJECT;
      else
         target = TGT_REMOTE;
   end
endmodule

// File: rtl/cfg_addr_gen.sv
module cfg_addr_gen
   import cfg_router_pkg::*;
#(
   parameter int                ADDR_W = 32,
   parameter logic [ADDR_W-1:0] BASE   = '0
) (
   input  logic [OFF_W-1:0]  off,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [OFF_W-1:0] ALIGN_MASK = ~(OFF_W'(3));
   logic [OFF_W-1:0] off_al;
   assign off_al = off & ALIGN_MASK;

   generate
      if (ADDR_W <= OFF_W) begin : g_bad
         $error("cfg_addr_gen: ADDR_W must exceed the offset width");
      end
      if (BASE[OFF_W-1:0] == '0) begin : g_concat
         assign addr = {BASE[ADDR_W-1:OFF_W], off_al};
      end else begin : g_add
         assign addr = BASE + ADDR_W'(off_al);
      end
   endgenerate
endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
   import cfg_router_pkg::*;
#(
   parameter int                DATA_W   = 32,
   parameter int                ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] LOC_BASE = 32'h4000_0000,
   parameter logic [ADDR_W-1:0] REM_BASE = 32'h6000_0000,
   localparam int               BE_W     = DATA_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busnum_we,
   input  logic [7:0]        busnum_root_in,
   input  logic [7:0]        busnum_sec_in,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [7:0]        req_bus,
   input  logic [4:0]        req_dev,
   input  logic [2:0]        req_fn,
   input  logic [11:0]       req_off,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [BE_W-1:0]   req_be,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              loc_valid,
   output logic              loc_write,
   output logic [ADDR_W-1:0] loc_addr,
   output logic [DATA_W-1:0] loc_wdata,
   output logic [BE_W-1:0]   loc_be,
   input  logic              loc_ack,
   input  logic [DATA_W-1:0] loc_rdata,
   output logic              win_we,
   output logic [31:0]       win_data,
   output logic              rem_valid,
   output logic              rem_write,
   output logic [ADDR_W-1:0] rem_addr,
   output logic [DATA_W-1:0] rem_wdata,
   output logic [BE_W-1:0]   rem_be,
   input  logic              rem_ack,
   input  logic [DATA_W-1:0] rem_rdata
);
   localparam int BDF_W = BUS_W + DEV_W + FN_W;

   generate
      if (DATA_W % 8 != 0 || DATA_W < 8) begin : g_bad_data
         $error("cfg_access_router: DATA_W must be a multiple of 8");
      end
      if (BDF_W != 16) begin : g_bad_bdf
         $error("cfg_access_router: bus/device/function must fill 16 bits");
      end
   endgenerate

   rtr_state_t        state_q;
   rtr_target_t       tgt;
   bdf_t              req_bdf, bdf_q;
   logic              write_q;
   logic [OFF_W-1:0]  off_q;
   logic [DATA_W-1:0] wdata_q, rdata_q;
   logic [BE_W-1:0]   be_q;
   logic [BUS_W-1:0]  root_q, sec_q;
   logic              accept;

   assign req_bdf = '{bus: req_bus, dev: req_dev, fn: req_fn};
   assign accept  = req_valid && req_ready;

   cfg_bus_regs u_busregs (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (busnum_we),
      .root_in (busnum_root_in),
      .sec_in  (busnum_sec_in),
      .root_q  (root_q),
      .sec_q   (sec_q)
   );

   cfg_filter u_filter (
      .bdf      (req_bdf),
      .root_bus (root_q),
      .sec_bus  (sec_q),
      .target   (tgt)
   );

   cfg_addr_gen #(.ADDR_W(ADDR_W), .BASE(LOC_BASE)) u_loc_addr (
      .off  (off_q),
      .addr (loc_addr)
   );

   cfg_addr_gen #(.ADDR_W(ADDR_W), .BASE(REM_BASE)) u_rem_addr (
      .off  (off_q),
      .addr (rem_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         bdf_q   <= '0;
         write_q <= 1'b0;
         off_q   <= '0;
         wdata_q <= '0;
         be_q    <= '0;
         rdata_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (req_valid) begin
               bdf_q   <= req_bdf;
               write_q <= req_write;
               off_q   <= req_off;
               wdata_q <= req_wdata;
               be_q    <= req_be;
               case (tgt)
                  TGT_LOCAL:  state_q <= ST_LOCAL;
                  TGT_REMOTE: state_q <= ST_WINDOW;
                  default: begin
                     rdata_q <= req_write ? '0 : '1;
                     state_q <= ST_RESP;
                  end
               endcase
            end
            ST_LOCAL: if (loc_ack) begin
               rdata_q <= write_q ? '0 : loc_rdata;
               state_q <= ST_RESP;
            end
            ST_WINDOW: state_q <= ST_REMOTE;
            ST_REMOTE: if (rem_ack) begin
               rdata_q <= write_q ? '0 : rem_rdata;
               state_q <= ST_RESP;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready = (state_q == ST_IDLE);
   assign rsp_valid = (state_q == ST_RESP);
   assign rsp_rdata = rdata_q;
   assign loc_valid = (state_q == ST_LOCAL);
   assign loc_write = write_q;
   assign loc_wdata = wdata_q;
   assign loc_be    = be_q;
   assign win_we    = (state_q == ST_WINDOW);
   assign win_data  = {bdf_q, 16'h0000};
   assign rem_valid = (state_q == ST_REMOTE);
   assign rem_write = write_q;
   assign rem_wdata = wdata_q;
   assign rem_be    = be_q;

   // R1
   root_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !req_write && req_bus == root_q && {req_dev, req_fn} != '0)
      |=> (rsp_valid && rsp_rdata == '1));

   // R2
   sec_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && req_bus != root_q && req_bus == sec_q && req_dev != '0)
      |=> rsp_valid);

   // R4
   win_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rem_valid) |-> $past(win_we));

   // R3
   loc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_valid && !loc_ack) |=> (loc_valid && $stable(loc_addr) && $stable(loc_be)));

   // R5
   rem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rem_valid && !rem_ack) |=> (rem_valid && $stable(rem_addr) && $stable(rem_be)));

   // R7
   busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);

   // R6
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({loc_valid, rem_valid, win_we, rsp_valid}));
endmodule

// File: tb/cfg_access_router_test.sv
module cfg_access_router_test;
   localparam logic [31:0] LB = 32'h4000_0000;
   localparam logic [31:0] RB = 32'h6000_0000;
   localparam logic [31:0] LX = 32'hC0DE_0000;
   localparam logic [31:0] RX = 32'h0BAD_0000;

   logic clk = 0;
   logic rst_n = 0;
   always #10 clk = ~clk;

   logic        busnum_we = 0;
   logic [7:0]  busnum_root_in = 0, busnum_sec_in = 0;
   logic        req_valid = 0, req_ready, req_write = 0;
   logic [7:0]  req_bus = 0;
   logic [4:0]  req_dev = 0;
   logic [2:0]  req_fn = 0;
   logic [11:0] req_off = 0;
   logic [31:0] req_wdata = 0;
   logic [3:0]  req_be = 0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic        loc_valid, loc_write, loc_ack = 0;
   logic [31:0] loc_addr, loc_wdata, loc_rdata = 0;
   logic [3:0]  loc_be;
   logic        win_we;
   logic [31:0] win_data;
   logic        rem_valid, rem_write, rem_ack = 0;
   logic [31:0] rem_addr, rem_wdata, rem_rdata = 0;
   logic [3:0]  rem_be;

   cfg_access_router #(.LOC_BASE(LB), .REM_BASE(RB)) uut (.*);

   int checks = 0, errors = 0, cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // target models and activity record
   int loc_cnt = 0, rem_cnt = 0, win_cnt = 0, loc_wait = 0, rem_wait = 0;
   int win_cyc = 0, rem_first_cyc = 0;
   logic [31:0] l_addr, l_wd, r_addr, r_wd, w_word;
   logic [3:0]  l_be, r_be;
   logic        l_wr, r_wr;

   always @(negedge clk) begin
      if (win_we) begin win_cnt++; w_word = win_data; win_cyc = cyc; end
      if (loc_valid && !loc_ack) begin
         loc_wait++;
         if (loc_wait >= 2) begin
            loc_ack = 1; loc_rdata = loc_addr ^ LX;
            l_addr = loc_addr; l_wd = loc_wdata; l_be = loc_be; l_wr = loc_write;
            loc_cnt++;
         end
      end else begin loc_ack = 0; loc_wait = 0; end
      if (rem_valid && !rem_ack) begin
         if (rem_wait == 0) rem_first_cyc = cyc;
         rem_wait++;
         if (rem_wait >= 3) begin
            rem_ack = 1; rem_rdata = rem_addr ^ RX;
            r_addr = rem_addr; r_wd = rem_wdata; r_be = rem_be; r_wr = rem_write;
            rem_cnt++;
         end
      end else begin rem_ack = 0; rem_wait = 0; end
   end

   // scoreboard: expected responses
   logic [31:0] exp_q[$];
   string       tag_q[$];
   int rsp_cnt = 0, rsp_cyc = 0;
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         rsp_cnt++; rsp_cyc = cyc;
         if (exp_q.size() == 0)
            chk(0, "R8 unexpected response", rsp_rdata, 32'h0);
         else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front(); t = tag_q.pop_front();
            chk(rsp_rdata === e, t, rsp_rdata, e);
         end
      end
   end

   logic [7:0] m_root = 0, m_sec = 1;

   task automatic issue(input bit w, input logic [7:0] b, input logic [4:0] d,
                        input logic [2:0] f, input logic [11:0] off,
                        input logic [31:0] wd, input logic [3:0] be,
                        input bit upd, input logic [7:0] nroot, input logic [7:0] nsec);
      int kind, lc, rc, wc, rs, t0;
      logic [31:0] eaddr, erd;
      if (b == m_root) kind = ({d, f} == 0) ? 1 : 0;
      else if (b == m_sec) kind = (d == 0) ? 2 : 0;
      else kind = 2;
      eaddr = ((kind == 1) ? LB : RB) + {20'h0, off & 12'hFFC};
      if (w) erd = 0;
      else if (kind == 0) erd = 32'hFFFF_FFFF;
      else erd = eaddr ^ ((kind == 1) ? LX : RX);
      exp_q.push_back(erd);
      tag_q.push_back(kind == 0 ? "R6 reject response" : "R8 forwarded response");
      lc = loc_cnt; rc = rem_cnt; wc = win_cnt; rs = rsp_cnt;
      @(negedge clk);
      req_valid = 1; req_write = w; req_bus = b; req_dev = d; req_fn = f;
      req_off = off; req_wdata = wd; req_be = be;
      busnum_we = upd; busnum_root_in = nroot; busnum_sec_in = nsec;
      t0 = cyc;
      @(negedge clk);
      req_valid = 0; busnum_we = 0;
      if (upd) begin m_root = nroot; m_sec = nsec; end
      chk(req_ready == 0, "R7 busy after accept", {31'h0, req_ready}, 32'h0);
      while (rsp_cnt == rs) @(negedge clk);
      if (kind == 0) begin
         chk(rsp_cyc - t0 == 1, "R6 reject latency", rsp_cyc - t0, 1);
         chk(loc_cnt == lc && rem_cnt == rc && win_cnt == wc, "R6 no target strobe",
             loc_cnt + rem_cnt + win_cnt, lc + rc + wc);
      end else if (kind == 1) begin
         chk(loc_cnt == lc + 1 && rem_cnt == rc && win_cnt == wc, "R3 local only", loc_cnt, lc + 1);
         chk(l_addr == eaddr, "R3 local address", l_addr, eaddr);
         chk(l_wr == w && l_be == be && (!w || l_wd == wd), "R3 local data/be",
             {l_wd[27:0], l_be}, {wd[27:0], be});
      end else begin
         chk(win_cnt == wc + 1 && rem_cnt == rc + 1 && loc_cnt == lc, "R5 remote only", rem_cnt, rc + 1);
         chk(w_word == {b, d, f, 16'h0}, "R4 window word", w_word, {b, d, f, 16'h0});
         chk(rem_first_cyc - win_cyc == 1, "R4 window precedes access", rem_first_cyc - win_cyc, 1);
         chk(r_addr == eaddr, "R5 remote address", r_addr, eaddr);
         chk(r_wr == w && r_be == be && (!w || r_wd == wd), "R5 remote data/be",
             {r_wd[27:0], r_be}, {wd[27:0], be});
      end
      @(negedge clk);
      chk(req_ready == 1, "R7 ready after response", {31'h0, req_ready}, 32'h1);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL R7 watchdog: actual=no completion expected=finished run");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(req_ready && !rsp_valid && !loc_valid && !rem_valid && !win_we, "R7 reset idle",
          {27'h0, req_ready, rsp_valid, loc_valid, rem_valid, win_we}, 32'h10);
      issue(0, 8'd0, 5'd0, 3'd0, 12'h010, 0, 4'hF, 0, 0, 0);            // R3 local read
      issue(1, 8'd0, 5'd0, 3'd0, 12'hFFF, 32'hDEAD_BEEF, 4'b0101, 0, 0, 0); // R3 write, unaligned low bits
      issue(0, 8'd0, 5'd0, 3'd1, 12'h020, 0, 4'hF, 0, 0, 0);            // R1 fn nonzero
      issue(1, 8'd0, 5'd3, 3'd0, 12'h020, 32'h1234_5678, 4'hF, 0, 0, 0); // R1 write dropped
      issue(0, 8'd1, 5'd0, 3'd5, 12'h104, 0, 4'hF, 0, 0, 0);            // R2 dev0 any fn
      issue(0, 8'd1, 5'd1, 3'd0, 12'h104, 0, 4'hF, 0, 0, 0);            // R2 dev nonzero
      issue(1, 8'd5, 5'd7, 3'd2, 12'h0A8, 32'hA5A5_0F0F, 4'b1100, 0, 0, 0); // R4 R5 deep bus
      issue(0, 8'd255, 5'd31, 3'd7, 12'hFFC, 0, 4'b0001, 0, 0, 0);       // R4 extreme fields
      // R9 load new numbers with a request judged under the defaults
      issue(0, 8'd0, 5'd0, 3'd0, 12'h008, 0, 4'hF, 1, 8'd4, 8'd5);
      issue(0, 8'd4, 5'd0, 3'd0, 12'h00C, 0, 4'hF, 0, 0, 0);            // R9 new root local
      issue(0, 8'd5, 5'd2, 3'd0, 12'h00C, 0, 4'hF, 0, 0, 0);            // R9 new secondary rejects
      issue(0, 8'd0, 5'd0, 3'd0, 12'h00C, 0, 4'hF, 0, 0, 0);            // R9 old root now remote
      // R9 same-edge: old root 4 rejects fn1; new root 9 would forward remote
      issue(0, 8'd4, 5'd0, 3'd1, 12'h040, 0, 4'hF, 1, 8'd9, 8'd10);
      issue(0, 8'd9, 5'd0, 3'd0, 12'h040, 0, 4'hF, 0, 0, 0);            // R9 new root in force
      repeat (2) @(negedge clk);
      chk(exp_q.size() == 0, "R8 all responses seen", exp_q.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule